// File: doc/BRIEF.md
# Page-Mode Multiplexed DRAM Controller

This block turns single-bit host reads and writes on a 16-bit address into the strobe sequences of a 64K x 1 dynamic memory. The memory is organised as 256 rows by 256 columns and is modelled inside the block, together with its row latch. The upper address byte selects the row and is sent first on a shared 8-bit address bus under an active-low row strobe. The lower byte selects the column and follows under an active-low column strobe.

Opening a row copies the whole row into the latch and wipes the row in the array. The controller therefore holds a row open while requests keep hitting it, serving each with a column strobe alone. Before it opens any other row it restores the current one from the latch. A free-running interval timer raises refresh requests. Each refresh opens the next row in turn and restores it. A refresh outranks queued host work as soon as the column access in flight has ended.

The host side uses a valid/ready handshake. Read data returns with a one-cycle valid pulse. Writes return nothing.

Top module: `pmdram_ctrl`

## Requirements
- R1: For each accepted request, `dram_addr` carries `req_addr[15:8]` in the cycle `dram_ras_n` falls and `req_addr[7:0]` in the cycle `dram_cas_n` falls. `dram_cas_n` only falls while `dram_ras_n` is low, and every access issues exactly one column strobe.
- R2: `dram_addr` holds the same value for at least the one cycle before each falling edge of either strobe.
- R3: A read returns on `rdata` the bit most recently written to that address (0 if never written), with `rvalid` high for exactly one cycle.
- R4: A request to the row that is already open causes no row-strobe activity, only one column strobe.
- R5: A request to a different row than the open one restores the open row first (row strobe rises), then opens the new row with one row-strobe fall, then issues the column strobe. A request from the idle state opens its row with one row-strobe fall.
- R6: The column strobe falls only after the row strobe has been low for at least `T_RAS_OPEN` cycles. It stays low for exactly `T_CAS` cycles and stays high for at least `T_PAGE - T_CAS` cycles before falling again.
- R7: The row strobe rises only after at least `T_WB` cycles with the row strobe low and the column strobe high. Because of this restore, a row whose contents were wiped by an earlier opening is never opened again before it has been restored, and data survives any number of row changes.
- R8: With no host traffic, refresh opens rows in ascending order, one row per refresh, wrapping from 255 to 0. Refreshes that start from the idle state are exactly `REF_INTERVAL` cycles apart.
- R9: While the host keeps a row busy with continuous hits, refresh still occurs. The open row is restored, the next refresh row is cycled, and later host requests reopen their row with correct data.
- R10: During and just after reset, `dram_ras_n` and `dram_cas_n` are 1, `rvalid` is 0 and `req_ready` is 1.
- R11: A write produces no `rvalid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_addr | input | 16 | Bit address: row in [15:8], column in [7:0] |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Write data bit |
| rdata | output | 1 | Read data bit, valid with `rvalid` |
| rvalid | output | 1 | One-cycle pulse when read data is ready |
| dram_ras_n | output | 1 | Active-low row strobe |
| dram_cas_n | output | 1 | Active-low column strobe |
| dram_addr | output | 8 | Multiplexed row/column address bus |

## Verification
The vector walk mixes accesses from idle, hits to the open row and misses to other rows. It counts row-strobe and column-strobe falls for each access, which separates the page-hit path from the restore-and-reopen path. A read back after the row was closed shows whether the restore really happened, because opening a row wipes it. Long idle stretches show refresh ordering and spacing. A stream of back-to-back hits shows that refresh still cuts in and that host data stays correct afterwards.

// File: rtl/pmdram_pkg.sv
package pmdram_pkg;

    localparam int ROW_W  = 8;
    localparam int COL_W  = 8;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int NROWS  = 1 << ROW_W;
    localparam int NCOLS  = 1 << COL_W;

    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [COL_W-1:0]  col_t;
    typedef logic [ADDR_W-1:0] haddr_t;
    typedef logic [BUS_W-1:0]  bus_t;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_RSETUP,
        SQ_RACT,
        SQ_CSETUP,
        SQ_CACT,
        SQ_CREC,
        SQ_OPEN,
        SQ_WB,
        SQ_RPRE
    } seq_state_e;

    typedef struct packed {
        row_t row;
        col_t col;
        logic we;
        logic wdata;
    } host_req_t;

    function automatic row_t row_of(haddr_t a);
        return a[ADDR_W-1:COL_W];
    endfunction

    function automatic col_t col_of(haddr_t a);
        return a[COL_W-1:0];
    endfunction

    function automatic int at_least_one(int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pmdram_refresh_timer.sv
module pmdram_refresh_timer
    import pmdram_pkg::*;
#(
    parameter int REF_INTERVAL = 781
) (
    input  logic clk,
    input  logic rst,
    input  logic rf_taken,
    output logic rf_pend
);
    localparam int TW = $clog2(REF_INTERVAL + 1);

    logic [TW-1:0] tick;
    logic          wrap;

    assign wrap = (tick == TW'(REF_INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick    <= '0;
            rf_pend <= 1'b0;
        end else begin
            tick <= wrap ? '0 : tick + 1'b1;
            if (wrap)
                rf_pend <= 1'b1;
            else if (rf_taken)
                rf_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/pmdram_array.sv
module pmdram_array
    import pmdram_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  bus_t abus,
    input  logic din,
    output logic dout,
    output logic stale_open
);
    logic [NCOLS-1:0] cells [NROWS];
    logic [NROWS-1:0] row_ok;
    logic [NCOLS-1:0] col_latch;
    row_t             open_row;
    logic             ras_q;
    logic             cas_q;
    row_t             r_sel;
    col_t             c_sel;

    assign r_sel = abus[ROW_W-1:0];
    assign c_sel = abus[COL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NROWS; i++) cells[i] <= '0;
            row_ok     <= '1;
            col_latch  <= '0;
            open_row   <= '0;
            ras_q      <= 1'b1;
            cas_q      <= 1'b1;
            dout       <= 1'b0;
            stale_open <= 1'b0;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            // row strobe falls: destructive read into the latch
            if (!ras_n && ras_q) begin
                open_row      <= r_sel;
                col_latch     <= cells[r_sel];
                cells[r_sel]  <= '0;
                row_ok[r_sel] <= 1'b0;
                stale_open    <= !row_ok[r_sel];
            end
            // column strobe falls: access one latch bit
            if (!cas_n && cas_q && !ras_n) begin
                if (!we_n) begin
                    col_latch[c_sel] <= din;
                    dout             <= din;
                end else begin
                    dout <= col_latch[c_sel];
                end
            end
            // row strobe rises: restore the row from the latch
            if (ras_n && !ras_q) begin
                cells[open_row]  <= col_latch;
                row_ok[open_row] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pmdram_seq.sv
module pmdram_seq
    import pmdram_pkg::*;
#(
    parameter int T_RAS_OPEN = 10,
    parameter int T_CAS      = 2,
    parameter int T_WB       = 6,
    parameter int T_PAGE     = 5
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    output logic   req_ready,
    input  haddr_t req_addr,
    input  logic   req_we,
    input  logic   req_wdata,
    output logic   rdata,
    output logic   rvalid,
    input  logic   rf_pend,
    output logic   rf_taken,
    output logic   ras_n,
    output logic   cas_n,
    output logic   we_n,
    output logic   din,
    output bus_t   abus,
    input  logic   dout
);
    localparam int T_REC = at_least_one(T_PAGE - T_CAS - 1);
    localparam int CNT_W = $clog2(max4(T_RAS_OPEN, T_CAS, T_WB, T_REC) + 1);

    seq_state_e       st;
    logic [CNT_W-1:0] cnt;
    host_req_t        cur;
    row_t             act_row;
    row_t             rf_row;
    logic             pend;
    logic             rf_mode;
    logic             accept;
    logic             hit;

    assign req_ready = ((st == SQ_IDLE) || (st == SQ_OPEN)) && !rf_pend;
    assign accept    = req_valid && req_ready;
    assign hit       = (row_of(req_addr) == act_row);
    assign rf_taken  = rf_pend && ((st == SQ_IDLE) || (st == SQ_RPRE));

    always_comb begin
        ras_n = 1'b1;
        cas_n = 1'b1;
        unique case (st)
            SQ_RACT, SQ_CSETUP, SQ_CREC, SQ_OPEN, SQ_WB: ras_n = 1'b0;
            SQ_CACT: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign abus = ((st == SQ_IDLE) || (st == SQ_RSETUP) || (st == SQ_RACT) || (st == SQ_RPRE))
                  ? bus_t'(act_row) : bus_t'(cur.col);
    assign we_n = !((st == SQ_CACT) && cur.we);
    assign din  = cur.wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            cnt     <= '0;
            cur     <= '0;
            act_row <= '0;
            rf_row  <= '0;
            pend    <= 1'b0;
            rf_mode <= 1'b0;
            rdata   <= 1'b0;
            rvalid  <= 1'b0;
        end else begin
            rvalid <= 1'b0;
            if (rf_taken) rf_row <= rf_row + 1'b1;
            unique case (st)
                SQ_IDLE: begin
                    if (rf_pend) begin
                        act_row <= rf_row;
                        rf_mode <= 1'b1;
                        st      <= SQ_RSETUP;
                    end else if (accept) begin
                        cur     <= '{row: row_of(req_addr), col: col_of(req_addr),
                                     we: req_we, wdata: req_wdata};
                        act_row <= row_of(req_addr);
                        st      <= SQ_RSETUP;
                    end
                end
                SQ_RSETUP: begin
                    cnt <= '0;
                    st  <= SQ_RACT;
                end
                SQ_RACT: begin
                    if (cnt == CNT_W'(T_RAS_OPEN - 1)) begin
                        cnt <= '0;
                        st  <= rf_mode ? SQ_WB : SQ_CSETUP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_CSETUP: begin
                    cnt <= '0;
                    st  <= SQ_CACT;
                end
                SQ_CACT: begin
                    if (cnt == CNT_W'(T_CAS - 1)) begin
                        cnt <= '0;
                        st  <= SQ_CREC;
                        if (!cur.we) begin
                            rdata  <= dout;
                            rvalid <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_CREC: begin
                    if (cnt == CNT_W'(T_REC - 1)) begin
                        cnt <= '0;
                        st  <= SQ_OPEN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_OPEN: begin
                    cnt <= '0;
                    if (rf_pend) begin
                        st <= SQ_WB;
                    end else if (accept) begin
                        cur <= '{row: row_of(req_addr), col: col_of(req_addr),
                                 we: req_we, wdata: req_wdata};
                        if (hit) begin
                            st <= SQ_CSETUP;
                        end else begin
                            pend <= 1'b1;
                            st   <= SQ_WB;
                        end
                    end
                end
                SQ_WB: begin
                    if (cnt == CNT_W'(T_WB - 1)) begin
                        cnt <= '0;
                        st  <= SQ_RPRE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_RPRE: begin
                    rf_mode <= 1'b0;
                    if (rf_pend) begin
                        act_row <= rf_row;
                        rf_mode <= 1'b1;
                        st      <= SQ_RSETUP;
                    end else if (pend) begin
                        act_row <= cur.row;
                        pend    <= 1'b0;
                        st      <= SQ_RSETUP;
                    end else begin
                        st <= SQ_IDLE;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pmdram_ctrl.sv
module pmdram_ctrl
    import pmdram_pkg::*;
#(
    parameter int T_RAS_OPEN   = 10,
    parameter int T_CAS        = 2,
    parameter int T_WB         = 6,
    parameter int T_PAGE       = 5,
    parameter int REF_INTERVAL = 781
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [15:0] req_addr,
    input  logic        req_we,
    input  logic        req_wdata,
    output logic        rdata,
    output logic        rvalid,
    output logic        dram_ras_n,
    output logic        dram_cas_n,
    output logic [7:0]  dram_addr
);
    logic rf_pend;
    logic rf_taken;
    logic we_n;
    logic din;
    logic dout;
    logic stale_open;
    bus_t abus;

    assign dram_addr = 8'(abus);

    pmdram_refresh_timer #(
        .REF_INTERVAL(REF_INTERVAL)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .rf_taken (rf_taken),
        .rf_pend  (rf_pend)
    );

    pmdram_seq #(
        .T_RAS_OPEN(T_RAS_OPEN),
        .T_CAS     (T_CAS),
        .T_WB      (T_WB),
        .T_PAGE    (T_PAGE)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (haddr_t'(req_addr)),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .rdata     (rdata),
        .rvalid    (rvalid),
        .rf_pend   (rf_pend),
        .rf_taken  (rf_taken),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .we_n      (we_n),
        .din       (din),
        .abus      (abus),
        .dout      (dout)
    );

    pmdram_array u_array (
        .clk        (clk),
        .rst        (rst),
        .ras_n      (dram_ras_n),
        .cas_n      (dram_cas_n),
        .we_n       (we_n),
        .abus       (abus),
        .din        (din),
        .dout       (dout),
        .stale_open (stale_open)
    );
endmodule

// File: rtl/pmdram_chk.sv
module pmdram_chk #(
    parameter int T_RAS_OPEN = 10,
    parameter int T_CAS      = 2,
    parameter int T_WB       = 6,
    parameter int T_PAGE     = 5
) (
    input logic       clk,
    input logic       rst,
    input logic       ras_n,
    input logic       cas_n,
    input logic [7:0] abus,
    input logic       rvalid,
    input logic       stale_open
);
    logic [15:0] ras_lo_run;
    logic [15:0] cas_lo_run;
    logic [15:0] cas_hi_run;
    logic [15:0] wb_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_lo_run <= '0;
            cas_lo_run <= '0;
            cas_hi_run <= '0;
            wb_run     <= '0;
        end else begin
            ras_lo_run <= ras_n ? '0 : ((&ras_lo_run) ? ras_lo_run : ras_lo_run + 1'b1);
            cas_lo_run <= cas_n ? '0 : ((&cas_lo_run) ? cas_lo_run : cas_lo_run + 1'b1);
            cas_hi_run <= !cas_n ? '0 : ((&cas_hi_run) ? cas_hi_run : cas_hi_run + 1'b1);
            wb_run     <= (ras_n || !cas_n) ? '0 : ((&wb_run) ? wb_run : wb_run + 1'b1);
        end
    end

    assert_cas_inside_ras_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> !ras_n);

    assert_row_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> $stable(abus));

    assert_col_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> $stable(abus));

    assert_rvalid_single_R3: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    assert_ras_to_cas_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> (ras_lo_run >= 16'(T_RAS_OPEN)));

    assert_cas_width_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n) |-> (cas_lo_run == 16'(T_CAS)));

    assert_cas_gap_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> (cas_hi_run >= 16'(T_PAGE - T_CAS)));

    assert_restore_time_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (wb_run >= 16'(T_WB)));

    assert_no_stale_open_R7: assert property (@(posedge clk) disable iff (rst)
        !stale_open);
endmodule

bind pmdram_ctrl pmdram_chk #(
    .T_RAS_OPEN(T_RAS_OPEN),
    .T_CAS     (T_CAS),
    .T_WB      (T_WB),
    .T_PAGE    (T_PAGE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ras_n      (dram_ras_n),
    .cas_n      (dram_cas_n),
    .abus       (dram_addr),
    .rvalid     (rvalid),
    .stale_open (stale_open)
);

// File: tb/pmdram_ctrl_tb_top.sv
module pmdram_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int REF_IV     = 781;
    localparam int NVEC       = 12;

    // vector: {we, addr[15:0], wdata, expected rdata, expected row-strobe falls[1:0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b1, 16'h1203, 1'b1, 1'b0, 2'd1},
        {1'b1, 16'h1204, 1'b0, 1'b0, 2'd0},
        {1'b0, 16'h1203, 1'b0, 1'b1, 2'd0},
        {1'b0, 16'h1204, 1'b0, 1'b0, 2'd0},
        {1'b1, 16'h3403, 1'b1, 1'b0, 2'd1},
        {1'b0, 16'h1203, 1'b0, 1'b1, 2'd1},
        {1'b0, 16'h3403, 1'b0, 1'b1, 2'd1},
        {1'b0, 16'h3404, 1'b0, 1'b0, 2'd0},
        {1'b1, 16'hFFFF, 1'b1, 1'b0, 2'd1},
        {1'b0, 16'hFFFF, 1'b0, 1'b1, 2'd0},
        {1'b0, 16'h00FF, 1'b0, 1'b0, 2'd1},
        {1'b0, 16'hFF00, 1'b0, 1'b0, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic        req_wdata = 1'b0;
    logic        rdata;
    logic        rvalid;
    logic        dram_ras_n;
    logic        dram_cas_n;
    logic [7:0]  dram_addr;

    int checks = 0;
    int fails  = 0;

    int         cyc = 0;
    int         ras_falls = 0;
    int         cas_falls = 0;
    logic [7:0] fall_row [16];
    int         fall_cyc [16];
    logic [7:0] last_row = '0;
    logic [7:0] last_col = '0;
    logic       mon_ras_q = 1'b1;
    logic       mon_cas_q = 1'b1;
    logic       watch_en = 1'b0;
    logic [7:0] watch_row = '0;
    logic       watch_hit = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmdram_ctrl #(.REF_INTERVAL(REF_IV)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_we     (req_we),
        .req_wdata  (req_wdata),
        .rdata      (rdata),
        .rvalid     (rvalid),
        .dram_ras_n (dram_ras_n),
        .dram_cas_n (dram_cas_n),
        .dram_addr  (dram_addr)
    );

    always @(posedge clk) begin
        cyc++;
        if (mon_ras_q && !dram_ras_n) begin
            fall_row[ras_falls % 16] = dram_addr;
            fall_cyc[ras_falls % 16] = cyc;
            last_row = dram_addr;
            if (watch_en && dram_addr == watch_row) watch_hit = 1'b1;
            ras_falls++;
        end
        if (mon_cas_q && !dram_cas_n) begin
            last_col = dram_addr;
            cas_falls++;
        end
        mon_ras_q = dram_ras_n;
        mon_cas_q = dram_cas_n;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_op(input logic we, input logic [15:0] a, input logic wd,
                         output int rv_n, output logic rd, output int rf, output int cf);
        int rf0;
        int cf0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_we    = we;
        req_wdata = wd;
        while (!req_ready) @(negedge clk);
        rf0 = ras_falls;
        cf0 = cas_falls;
        @(negedge clk);
        req_valid = 1'b0;
        rv_n = 0;
        rd   = 1'b0;
        while (!req_ready) begin
            if (rvalid) begin
                rv_n++;
                rd = rdata;
            end
            @(negedge clk);
        end
        if (rvalid) begin
            rv_n++;
            rd = rdata;
        end
        rf = ras_falls - rf0;
        cf = cas_falls - cf0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int         rv_n;
        int         rf;
        int         cf;
        logic       rd;
        int         base;
        logic [7:0] r0;
        logic [7:0] r1;
        logic [7:0] r2;
        logic       bad_data;

        // R10 reset state
        repeat (3) @(negedge clk);
        check(dram_ras_n === 1'b1 && dram_cas_n === 1'b1, "R10 strobes idle in reset",
              int'({dram_ras_n, dram_cas_n}), 3);
        check(rvalid === 1'b0, "R10 rvalid low in reset", int'(rvalid), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready === 1'b1, "R10 ready after reset", int'(req_ready), 1);
        check(dram_ras_n === 1'b1, "R10 row strobe high after reset", int'(dram_ras_n), 1);

        // vector walk (R1 R3 R4 R5 R11)
        for (int i = 0; i < NVEC; i++) begin
            logic        v_we;
            logic [15:0] v_a;
            logic        v_wd;
            logic        v_exp;
            int          v_rf;
            {v_we, v_a, v_wd, v_exp} = VEC[i][20:2];
            v_rf = int'(VEC[i][1:0]);
            do_op(v_we, v_a, v_wd, rv_n, rd, rf, cf);
            check(rf == v_rf, (v_rf == 0) ? "R4 page hit without row strobe"
                                          : "R5 one row opening", rf, v_rf);
            check(cf == 1, "R1 one column strobe per access", cf, 1);
            check(last_col == v_a[7:0], "R1 column half on bus", int'(last_col), int'(v_a[7:0]));
            if (v_rf != 0)
                check(last_row == v_a[15:8], "R1 row half on bus", int'(last_row), int'(v_a[15:8]));
            if (v_we) begin
                check(rv_n == 0, "R11 write gives no rvalid", rv_n, 0);
            end else begin
                check(rv_n == 1, "R3 one rvalid pulse", rv_n, 1);
                check(rd == v_exp, "R3 read data", int'(rd), int'(v_exp));
            end
        end

        // R8 idle refresh order and spacing
        base = ras_falls;
        while (ras_falls < base + 3) @(negedge clk);
        r0 = fall_row[base % 16];
        r1 = fall_row[(base + 1) % 16];
        r2 = fall_row[(base + 2) % 16];
        check(r1 == r0 + 8'd1, "R8 refresh row step", int'(r1), int'(r0 + 8'd1));
        check(r2 == r1 + 8'd1, "R8 refresh row step", int'(r2), int'(r1 + 8'd1));
        check(fall_cyc[(base + 2) % 16] - fall_cyc[(base + 1) % 16] == REF_IV,
              "R8 refresh interval",
              fall_cyc[(base + 2) % 16] - fall_cyc[(base + 1) % 16], REF_IV);

        // R9 refresh cuts into a stream of page hits
        watch_row = r2 + 8'd1;
        watch_hit = 1'b0;
        watch_en  = 1'b1;
        bad_data  = 1'b0;
        for (int k = 0; k < 400 && !watch_hit; k++) begin
            logic [15:0] a;
            logic        e;
            a = (k % 2 == 1) ? 16'h1204 : 16'h1203;
            e = (k % 2 == 1) ? 1'b0 : 1'b1;
            do_op(1'b0, a, 1'b0, rv_n, rd, rf, cf);
            if (rv_n != 1 || rd != e) bad_data = 1'b1;
        end
        watch_en = 1'b0;
        check(watch_hit, "R9 refresh during hit stream", int'(watch_hit), 1);
        do_op(1'b0, 16'h1203, 1'b0, rv_n, rd, rf, cf);
        check(rf == 1, "R9 host row reopened after refresh", rf, 1);
        check(rd == 1'b1 && rv_n == 1, "R9 data after refresh", int'(rd), 1);
        check(!bad_data, "R9 hit stream data", int'(bad_data), 0);
        do_op(1'b0, 16'h3403, 1'b0, rv_n, rd, rf, cf);
        check(rd == 1'b1, "R7 data survives row changes", int'(rd), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule